// File: doc/BRIEF.md
# OTP Page Controller Register Interface

This block is the software-facing front end of a one-time-programmable array organised as 128-bit pages. It contains a small memory-mapped register file: a command register that carries a page number and two trigger bits, a 16-bit byte-enable mask, a completion status register, a timing register that is plain storage, and four 32-bit staging registers that together hold one page. Here the array itself is ordinary RAM that can be read and written any number of times.

Software fills the staging registers and sets the byte mask. It then writes the command register with a page number and the write trigger, the read trigger, or both. The transfer takes place in the same clock cycle as that register write. Only the bytes enabled in the mask move, and disabled destination bytes keep their old value. When both triggers are set, the page is written first and then read back into the staging registers. Each command write sets a done flag, and software clears it by writing a one to that bit.

Each register accepts only one access width. An access of the wrong width, or to an address that holds no register, is flagged on an error output and changes nothing.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset, the command register and the status register read 0x0000, the byte mask reads 0xFFFF, timing reads 0x00001485, and all four staging registers read 0.
- R2: The command (0x00), mask (0x04) and status (0x08) registers accept only size 2. Timing (0x0C) and the staging registers (0x80, 0x84, 0x88, 0x8C) accept only size 4. Any other size raises bus_err in the access cycle, leaves every register and the page array unchanged, and returns read data 0.
- R3: An access to any other address raises bus_err, leaves all state unchanged, and returns read data 0. This covers the gap 0x10 to 0x7C, addresses above 0x8C, and addresses that are not word-aligned.
- R4: A command write stores only the written bits under mask 0x39FF. The write trigger is bit 15 and the read trigger is bit 14, and both always read back as 0. The page number is bits [8:0].
- R5: A command write with bit 15 set copies the staging registers into the addressed page. Page byte n is bits [8(n mod 4)+7 : 8(n mod 4)] of staging word n/4. Byte n is copied only when mask bit n is 1.
- R6: A command write with bit 14 set copies the addressed page into the staging registers, using the same byte mapping. Staging bytes whose mask bit is 0 keep their old value.
- R7: When bits 15 and 14 are both set, the page write takes effect before the page read.
- R8: Every accepted command write sets status bit 0 (done). A status write clears each status bit that is written as 1 and leaves the bits written as 0 unchanged.
- R9: All 16 mask bits and all 32 timing bits are writable and read back as written.
- R10: Each staging register reads back the last value written to it, unless a page read has since replaced some of its bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_size | input | 3 | Access size in bytes (2 or 4 are legal) |
| bus_wdata | input | 32 | Write data; 16-bit registers use bits [15:0] |
| bus_rdata | output | 32 | Read data in the access cycle, zero-extended |
| bus_err | output | 1 | Wrong width or unmapped address in this cycle |

## Verification
Directed sequences use all-ones, single-nibble and empty byte masks. These separate a correct per-byte merge from whole-page copies and from byte indexes that are swapped between words. A command with both triggers set, aimed at a page with different prior contents, shows whether the write is ordered before the read. Random mixes of staging writes, mask changes, commands on a small pool of pages that includes the last page, and illegal widths and addresses are checked against a bench model. This shows whether rejected accesses leave any trace and whether page numbers alias.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int unsigned REG_AW      = 8;
    localparam int unsigned PAGE_WORDS  = 4;
    localparam int unsigned PAGE_BYTES  = PAGE_WORDS * 4;
    localparam int unsigned PAGE_BITS   = PAGE_BYTES * 8;

    localparam logic [REG_AW-1:0] OFF_CMD   = 8'h00;
    localparam logic [REG_AW-1:0] OFF_MASK  = 8'h04;
    localparam logic [REG_AW-1:0] OFF_STAT  = 8'h08;
    localparam logic [REG_AW-1:0] OFF_TIME  = 8'h0C;
    localparam logic [REG_AW-1:0] OFF_STAGE = 8'h80;

    localparam logic [15:0] CMD_KEEP   = 16'h39FF;
    localparam logic [15:0] MASK_INIT  = 16'hFFFF;
    localparam logic [31:0] TIME_INIT  = 32'h0000_1485;
    localparam int unsigned WR_TRIG    = 15;
    localparam int unsigned RD_TRIG    = 14;
    localparam int unsigned DONE_BIT   = 0;

    typedef enum logic [2:0] {
        HIT_NONE,
        HIT_CMD,
        HIT_MASK,
        HIT_STAT,
        HIT_TIME,
        HIT_STAGE
    } reg_hit_e;

    typedef logic [PAGE_WORDS-1:0][31:0] page_t;

    function automatic page_t byte_merge(input page_t keep, input page_t take,
                                         input logic [PAGE_BYTES-1:0] en);
        page_t res;
        res = keep;
        for (int b = 0; b < int'(PAGE_BYTES); b++) begin
            if (en[b]) res[b/4][8*(b%4) +: 8] = take[b/4][8*(b%4) +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/otp_reg_decode.sv
module otp_reg_decode
    import otp_pkg::*;
(
    input  logic              sel,
    input  logic [REG_AW-1:0] addr,
    input  logic [2:0]        size,
    output reg_hit_e          hit,
    output logic [1:0]        word_idx,
    output logic              err
);
    logic half_ok;
    logic word_ok;

    always_comb begin
        half_ok  = (size == 3'd2);
        word_ok  = (size == 3'd4);
        hit      = HIT_NONE;
        word_idx = addr[3:2];
        // width is judged before the address
        if (half_ok || word_ok) begin
            if      (addr == OFF_CMD  && half_ok) hit = HIT_CMD;
            else if (addr == OFF_MASK && half_ok) hit = HIT_MASK;
            else if (addr == OFF_STAT && half_ok) hit = HIT_STAT;
            else if (addr == OFF_TIME && word_ok) hit = HIT_TIME;
            else if (addr[7:4] == OFF_STAGE[7:4] && addr[1:0] == 2'b00 && word_ok)
                hit = HIT_STAGE;
        end
        err = sel && (hit == HIT_NONE);
    end

endmodule

// File: rtl/otp_page_array.sv
module otp_page_array
    import otp_pkg::*;
#(
    parameter int unsigned PAGE_COUNT = 512,
    localparam int unsigned PAW       = $clog2(PAGE_COUNT)
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [PAW-1:0]        page,
    input  page_t                 wr_data,
    input  logic [PAGE_BYTES-1:0] wr_mask,
    output page_t                 rd_data
);
    page_t cells [PAGE_COUNT];

    assign rd_data = cells[page];

    always_ff @(posedge clk) begin
        if (wr_en) cells[page] <= byte_merge(cells[page], wr_data, wr_mask);
    end

endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl
    import otp_pkg::*;
#(
    parameter int unsigned PAGE_COUNT = 512,
    localparam int unsigned PAW       = $clog2(PAGE_COUNT)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [2:0]  bus_size,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_err
);
    typedef struct packed {
        logic [15:0] cmd;
        logic [15:0] mask;
        logic [15:0] stat;
        logic [31:0] timing;
        page_t       stage;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_hit_e hit;
    logic [1:0] widx;
    logic     acc_ok;
    logic     wr_ok;
    logic     arr_we;
    logic [PAW-1:0] page_sel;
    page_t    arr_rd;
    page_t    page_after;

    otp_reg_decode dec_i (
        .sel      (bus_sel),
        .addr     (bus_addr),
        .size     (bus_size),
        .hit      (hit),
        .word_idx (widx),
        .err      (bus_err)
    );

    assign page_sel = bus_wdata[PAW-1:0];

    otp_page_array #(.PAGE_COUNT(PAGE_COUNT)) arr_i (
        .clk     (clk),
        .wr_en   (arr_we),
        .page    (page_sel),
        .wr_data (regs_q.stage),
        .wr_mask (regs_q.mask),
        .rd_data (arr_rd)
    );

    always_comb begin
        regs_d     = regs_q;
        acc_ok     = bus_sel && !bus_err;
        wr_ok      = acc_ok && bus_we;
        arr_we     = 1'b0;
        page_after = bus_wdata[WR_TRIG] ? byte_merge(arr_rd, regs_q.stage, regs_q.mask)
                                        : arr_rd;
        if (wr_ok) begin
            unique case (hit)
                HIT_CMD: begin
                    regs_d.cmd            = bus_wdata[15:0] & CMD_KEEP;
                    arr_we                = bus_wdata[WR_TRIG];
                    regs_d.stat[DONE_BIT] = 1'b1;
                    if (bus_wdata[RD_TRIG])
                        regs_d.stage = byte_merge(regs_q.stage, page_after, regs_q.mask);
                end
                HIT_MASK:  regs_d.mask        = bus_wdata[15:0];
                HIT_STAT:  regs_d.stat        = regs_q.stat & ~bus_wdata[15:0];
                HIT_TIME:  regs_d.timing      = bus_wdata;
                HIT_STAGE: regs_d.stage[widx] = bus_wdata;
                default: ;
            endcase
        end

        bus_rdata = '0;
        if (acc_ok && !bus_we) begin
            unique case (hit)
                HIT_CMD:   bus_rdata = {16'h0, regs_q.cmd};
                HIT_MASK:  bus_rdata = {16'h0, regs_q.mask};
                HIT_STAT:  bus_rdata = {16'h0, regs_q.stat};
                HIT_TIME:  bus_rdata = regs_q.timing;
                HIT_STAGE: bus_rdata = regs_q.stage[widx];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.cmd    <= '0;
            regs_q.mask   <= MASK_INIT;
            regs_q.stat   <= '0;
            regs_q.timing <= TIME_INIT;
            regs_q.stage  <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_size != 3'd2 && bus_size != 3'd4) |-> (bus_err && bus_rdata == 32'h0)); // R2

    AST_GAP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr >= 8'h10 && bus_addr < 8'h80) |-> bus_err); // R3

    AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_err) |=> (regs_q == $past(regs_q))); // R3

    AST_CMD_STORE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !bus_err && bus_addr == OFF_CMD)
        |=> (regs_q.cmd == ($past(bus_wdata[15:0]) & CMD_KEEP))); // R4

    AST_DONE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !bus_err && bus_addr == OFF_CMD) |=> regs_q.stat[DONE_BIT]); // R8

    AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !bus_err && bus_addr == OFF_STAT)
        |=> ((regs_q.stat & $past(bus_wdata[15:0])) == 16'h0)); // R8

    AST_RD_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !bus_err && bus_addr == OFF_CMD && regs_q.mask == 16'h0)
        |=> $stable(regs_q.stage)); // R6

endmodule

// File: tb/otp_page_ctrl_tb.sv
`timescale 1ns/1ps
module otp_page_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    otp_page_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    // bench model
    logic [127:0] m_page [512];
    logic [15:0]  m_cmd, m_mask, m_stat;
    logic [31:0]  m_time;
    logic [127:0] m_stage;

    function automatic logic [127:0] mix(input logic [127:0] oldv, input logic [127:0] newv,
                                         input logic [15:0] en);
        logic [127:0] r = oldv;
        for (int b = 0; b < 16; b++) if (en[b]) r[8*b +: 8] = newv[8*b +: 8];
        return r;
    endfunction

    function automatic logic legal(input logic [7:0] a, input logic [2:0] sz);
        if (a == 8'h00 || a == 8'h04 || a == 8'h08) return sz == 3'd2;
        if (a == 8'h0C || a == 8'h80 || a == 8'h84 || a == 8'h88 || a == 8'h8C) return sz == 3'd4;
        return 1'b0;
    endfunction

    function automatic logic [31:0] mread(input logic [7:0] a);
        case (a)
            8'h00: return {16'h0, m_cmd};
            8'h04: return {16'h0, m_mask};
            8'h08: return {16'h0, m_stat};
            8'h0C: return m_time;
            8'h80, 8'h84, 8'h88, 8'h8C: return m_stage[32*a[3:2] +: 32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic mwrite(input logic [7:0] a, input logic [31:0] wd);
        logic [8:0] pg;
        case (a)
            8'h00: begin
                pg = wd[8:0];
                if (wd[15]) m_page[pg] = mix(m_page[pg], m_stage, m_mask);
                if (wd[14]) m_stage = mix(m_stage, m_page[pg], m_mask);
                m_cmd = wd[15:0] & 16'h39FF;
                m_stat[0] = 1'b1;
            end
            8'h04: m_mask = wd[15:0];
            8'h08: m_stat = m_stat & ~wd[15:0];
            8'h0C: m_time = wd;
            default: m_stage[32*a[3:2] +: 32] = wd;
        endcase
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic we, input logic [7:0] a, input logic [2:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output logic er);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
        #1;
        rd = bus_rdata; er = bus_err;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input string req, input logic [7:0] a, input logic [2:0] sz,
                      input logic [31:0] wd);
        logic [31:0] rd; logic er;
        bus_op(1'b1, a, sz, wd, rd, er);
        chk({req, " err"}, {31'h0, er}, {31'h0, !legal(a, sz)});
        if (legal(a, sz)) mwrite(a, wd);
    endtask

    task automatic rdc(input string req, input logic [7:0] a, input logic [2:0] sz);
        logic [31:0] rd; logic er;
        bus_op(1'b0, a, sz, 32'h0, rd, er);
        chk({req, " err"}, {31'h0, er}, {31'h0, !legal(a, sz)});
        chk({req, " data"}, rd, legal(a, sz) ? mread(a) : 32'h0);
    endtask

    task automatic rd_all(input string req);
        rdc(req, 8'h00, 3'd2); rdc(req, 8'h04, 3'd2); rdc(req, 8'h08, 3'd2);
        rdc(req, 8'h0C, 3'd4);
        for (int i = 0; i < 4; i++) rdc(req, 8'h80 + 8'(4*i), 3'd4);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd; logic er;
        void'($urandom(32'h0715_5EED));
        for (int p = 0; p < 512; p++) m_page[p] = '0;
        m_cmd = 16'h0; m_mask = 16'hFFFF; m_stat = 16'h0; m_time = 32'h1485; m_stage = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values, with fixed constants as well
        bus_op(1'b0, 8'h04, 3'd2, 0, rd, er); chk("R1 mask reset", rd, 32'h0000_FFFF);
        bus_op(1'b0, 8'h0C, 3'd4, 0, rd, er); chk("R1 timing reset", rd, 32'h0000_1485);
        rd_all("R1");

        // clear pages used by the bench so the array holds known contents
        wr("R5 init", 8'h04, 3'd2, 32'hFFFF);
        foreach (m_stage[i]) m_stage[i] = m_stage[i];
        for (int i = 0; i < 4; i++) wr("R10 init", 8'h80 + 8'(4*i), 3'd4, 32'h0);
        for (int p = 0; p < 8; p++) wr("R5 init", 8'h00, 3'd2, 32'h8000 | p);
        wr("R5 init", 8'h00, 3'd2, 32'h8000 | 32'd510);
        wr("R5 init", 8'h00, 3'd2, 32'h8000 | 32'd511);

        // R9 mask and timing storage
        wr("R9", 8'h04, 3'd2, 32'h0000_A5C3); rdc("R9", 8'h04, 3'd2);
        wr("R9", 8'h0C, 3'd4, 32'hDEAD_BEEF); rdc("R9", 8'h0C, 3'd4);
        // R10 staging storage
        for (int i = 0; i < 4; i++) wr("R10", 8'h80 + 8'(4*i), 3'd4, 32'h1111_1111 * (i + 1));
        rd_all("R10");

        // R4 stored bits and page field, no triggers
        wr("R4", 8'h00, 3'd2, 32'h0000_07FF);
        bus_op(1'b0, 8'h00, 3'd2, 0, rd, er); chk("R4 cmd mask", rd, 32'h0000_01FF);
        // R8 done set, write 0 keeps, write 1 clears
        rdc("R8", 8'h08, 3'd2);
        wr("R8", 8'h08, 3'd2, 32'h0000_0000);
        bus_op(1'b0, 8'h08, 3'd2, 0, rd, er); chk("R8 done kept", rd, 32'h1);
        wr("R8", 8'h08, 3'd2, 32'h0000_0001);
        bus_op(1'b0, 8'h08, 3'd2, 0, rd, er); chk("R8 done cleared", rd, 32'h0);

        // R5/R6 masked page write then masked read
        wr("R5", 8'h04, 3'd2, 32'hFFFF);
        for (int i = 0; i < 4; i++) wr("R5", 8'h80 + 8'(4*i), 3'd4, 32'hA0A1_A2A3 + i);
        wr("R5", 8'h00, 3'd2, 32'h8005);
        for (int i = 0; i < 4; i++) wr("R6", 8'h80 + 8'(4*i), 3'd4, 32'h0);
        wr("R6", 8'h04, 3'd2, 32'h00F0);
        wr("R6", 8'h00, 3'd2, 32'h4005);
        bus_op(1'b0, 8'h84, 3'd4, 0, rd, er); chk("R6 enabled word", rd, 32'hA0A1_A2A4);
        bus_op(1'b0, 8'h80, 3'd4, 0, rd, er); chk("R6 disabled word", rd, 32'h0);
        wr("R6", 8'h04, 3'd2, 32'h0000);
        wr("R6", 8'h00, 3'd2, 32'h4005);
        rd_all("R6 empty mask");

        // R7 write before read on page 7
        wr("R7", 8'h04, 3'd2, 32'hFFFF);
        for (int i = 0; i < 4; i++) wr("R7", 8'h80 + 8'(4*i), 3'd4, 32'hC000_0000 + i);
        wr("R7", 8'h00, 3'd2, 32'h8007);
        for (int i = 0; i < 4; i++) wr("R7", 8'h80 + 8'(4*i), 3'd4, 32'hB000_0000 + i);
        wr("R7", 8'h04, 3'd2, 32'h000F);
        wr("R7", 8'h00, 3'd2, 32'hC007);
        wr("R7", 8'h04, 3'd2, 32'hFFFF);
        wr("R7", 8'h00, 3'd2, 32'h4007);
        bus_op(1'b0, 8'h80, 3'd4, 0, rd, er); chk("R7 written byte word", rd, 32'hB000_0000);
        bus_op(1'b0, 8'h84, 3'd4, 0, rd, er); chk("R7 old word", rd, 32'hC000_0001);

        // R2 wrong widths
        wr("R2", 8'h04, 3'd4, 32'h1234);
        wr("R2", 8'h80, 3'd2, 32'h5555);
        wr("R2", 8'h0C, 3'd1, 32'h7777);
        wr("R2", 8'h00, 3'd4, 32'h8001);
        rdc("R2", 8'h08, 3'd4);
        rd_all("R2 unchanged");
        // R3 unmapped addresses
        wr("R3", 8'h40, 3'd4, 32'hFFFF_FFFF);
        wr("R3", 8'h90, 3'd4, 32'hFFFF_FFFF);
        wr("R3", 8'h02, 3'd2, 32'h8003);
        wr("R3", 8'h7C, 3'd4, 32'h1);
        rdc("R3", 8'h10, 3'd4);
        rd_all("R3 unchanged");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned kind = $urandom % 8;
            logic [8:0] pg;
            case ($urandom % 6)
                0: pg = 9'd0; 1: pg = 9'd1; 2: pg = 9'd2; 3: pg = 9'd3;
                4: pg = 9'd510; default: pg = 9'd511;
            endcase
            case (kind)
                0: wr("R10 rnd", 8'h80 + 8'(4*($urandom % 4)), 3'd4, $urandom);
                1: wr("R6 rnd mask", 8'h04, 3'd2,
                      ($urandom % 4 == 0) ? 32'hFFFF : ($urandom & 32'hFFFF));
                2, 3: wr("R7 rnd cmd", 8'h00, 3'd2,
                      (($urandom % 4) << 14) | ($urandom & 32'h3E00) | pg);
                4: wr("R8 rnd stat", 8'h08, 3'd2, $urandom & 32'hFFFF);
                5: wr("R2 rnd width", 8'(4*($urandom % 4)), 3'($urandom % 5), $urandom);
                6: rdc("R3 rnd addr", 8'($urandom), 3'd4);
                default: rdc("R10 rnd rd", 8'h80 + 8'(4*($urandom % 4)), 3'd4);
            endcase
        end
        rd_all("R5 final");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule